// File: doc/BRIEF.md
# Line Loopback Mode Controller

This block steers serial bit streams inside a line transceiver. It sits between two sources and two sinks. The sources are the recovered receive stream and the system transmit stream, each a data bus with its bit clock. The sinks are the transmitter input and the receive output toward the system. The block has three routings. In normal operation each stream goes straight through. In remote loopback the recovered line data, with its recovered clock, is sent back out through the transmitter. In local loopback the system's transmit stream is sent back into the receive output.

The wanted routing comes from one of two places, chosen by a select input. The first is a pair of register bits, one for local and one for remote loopback. The second is a three-level strap, already decoded to a 2-bit code. All inputs are sampled by a core clock that runs faster than either bit clock. The routing never changes in the middle of a bit. A new routing is adopted on the core cycle in which the bit clock of the newly selected stream is seen rising. The outputs are registered, so they follow the inputs one core cycle later. A 2-bit status output reports which routing is in force.

Top module: `line_loop_sel`

## Requirements
- R1: While `rstN` is low, every data and clock output is 0 and `modeStatus` is 00 (normal).
- R2: With `hwSel` low, the request is: local loopback when `swLocalEn` is 1 (whatever `swRemoteEn` is), remote loopback when only `swRemoteEn` is 1, normal when both are 0. The strap code has no effect.
- R3: With `hwSel` high, the request is: normal for strap code 00, remote loopback for 01, local loopback for 10, and normal for 11. The two register bits have no effect.
- R4: In normal routing, `txDataOut`/`txClkOut` equal `txDataIn`/`txClkIn` and `rxDataOut`/`rxClkOut` equal `rxDataIn`/`rxClkIn`, each delayed by one core cycle.
- R5: In remote loopback, `txDataOut`/`txClkOut` carry `rxDataIn`/`rxClkIn` one core cycle late. `rxDataOut`/`rxClkOut` keep carrying the recovered stream.
- R6: In local loopback, `rxDataOut`/`rxClkOut` carry `txDataIn`/`txClkIn` one core cycle late. `txDataOut`/`txClkOut` keep carrying the transmit stream.
- R7: A request that differs from the routing in force is adopted only at a core edge where the bit clock of the newly selected stream is 1 and was 0 at the previous core edge. The newly selected stream is:
  - the receive stream when entering remote loopback;
  - the transmit stream when entering local loopback;
  - the transmit stream when going from remote loopback to normal;
  - the receive stream when going from local loopback to normal.

  The status and the routing switch at that same edge.
- R8: A request that is withdrawn before its bit-clock edge occurs leaves both the routing and the status unchanged.
- R9: `modeStatus` reports the routing in force: 00 normal, 01 remote loopback, 10 local loopback. The value 11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hwSel | input | 1 | 1: strap sets the routing, 0: register bits set it |
| swLocalEn | input | 1 | Register bit requesting local loopback |
| swRemoteEn | input | 1 | Register bit requesting remote loopback |
| strapCode | input | 2 | Decoded strap: 00 low, 01 floating, 10 high |
| rxDataIn | input | DATA_W | Recovered receive data |
| rxClkIn | input | 1 | Recovered receive bit clock |
| txDataIn | input | DATA_W | System transmit data |
| txClkIn | input | 1 | System transmit bit clock |
| txDataOut | output | DATA_W | Data toward the transmitter |
| txClkOut | output | 1 | Bit clock toward the transmitter |
| rxDataOut | output | DATA_W | Data toward the system receive side |
| rxClkOut | output | 1 | Bit clock toward the system receive side |
| modeStatus | output | 2 | Routing in force (00/01/10) |

## Verification
The bench steps through every ordered pair of the 32 input configurations while both bit clocks run at unrelated rates. It compares every output on every cycle against a cycle model.

These sweeps target specific mistakes:
- Mixing up the two loopback directions makes the transmit and receive outputs differ from the model.
- Letting the strap leak into software mode, or the register bits into hardware mode, gives a wrong status.
- Giving remote priority when both register bits are set also gives a wrong status.
- Switching on the old stream's clock edge, or as soon as the request arrives, moves the change to the wrong cycle. That shows up as a clipped bit on the clock outputs.

A directed case freezes both bit clocks while a request comes and goes. Any design that commits without an edge would show a status change there.

// File: rtl/llsPkg.sv
package llsPkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_REMOTE = 2'b01,
    MODE_LOCAL  = 2'b10
  } loopModeE;

  // Routing strobes from control to datapath, valid for the coming edge
  typedef struct packed {
    logic txFromRx;
    logic rxFromTx;
  } pathStrobeS;

  function automatic loopModeE strapToMode(input logic [1:0] code);
    case (code)
      2'b01:   return MODE_REMOTE;
      2'b10:   return MODE_LOCAL;
      default: return MODE_NORMAL;
    endcase
  endfunction

  function automatic loopModeE regToMode(input logic localEn, input logic remoteEn);
    if (localEn)       return MODE_LOCAL;
    else if (remoteEn) return MODE_REMOTE;
    else               return MODE_NORMAL;
  endfunction

endpackage

// File: rtl/lls_mode_ctrl.sv
module lls_mode_ctrl
  import llsPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hwSel,
  input  logic       swLocalEn,
  input  logic       swRemoteEn,
  input  logic [1:0] strapCode,
  input  logic       rxClkIn,
  input  logic       txClkIn,
  output pathStrobeS strobe,
  output loopModeE   effMode
);

  logic     rxClkQ, txClkQ;
  logic     rxRise, txRise;
  logic     useRxEdge, commit;
  loopModeE reqMode, nextMode, effQ;

  always_comb begin
    if (hwSel) reqMode = strapToMode(strapCode);
    else       reqMode = regToMode(swLocalEn, swRemoteEn);
  end

  assign rxRise = rxClkIn & ~rxClkQ;
  assign txRise = txClkIn & ~txClkQ;

  // Which stream becomes newly selected by this transition
  always_comb begin
    case (reqMode)
      MODE_REMOTE: useRxEdge = 1'b1;
      MODE_LOCAL:  useRxEdge = 1'b0;
      default:     useRxEdge = (effQ == MODE_LOCAL);
    endcase
  end

  assign commit   = (reqMode != effQ) && (useRxEdge ? rxRise : txRise);
  assign nextMode = commit ? reqMode : effQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxClkQ <= 1'b0;
      txClkQ <= 1'b0;
      effQ   <= MODE_NORMAL;
    end else begin
      rxClkQ <= rxClkIn;
      txClkQ <= txClkIn;
      effQ   <= nextMode;
    end
  end

  assign strobe.txFromRx = (nextMode == MODE_REMOTE);
  assign strobe.rxFromTx = (nextMode == MODE_LOCAL);
  assign effMode         = effQ;

endmodule

// File: rtl/lls_datapath.sv
module lls_datapath
  import llsPkg::*;
#(
  parameter int DATA_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathStrobeS        strobe,
  input  logic [DATA_W-1:0] rxDataIn,
  input  logic              rxClkIn,
  input  logic [DATA_W-1:0] txDataIn,
  input  logic              txClkIn,
  output logic [DATA_W-1:0] txDataOut,
  output logic              txClkOut,
  output logic [DATA_W-1:0] rxDataOut,
  output logic              rxClkOut
);

  logic [DATA_W-1:0] txDataQ, rxDataQ;
  logic              txClkQ, rxClkQ;

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        txDataQ[i] <= 1'b0;
        rxDataQ[i] <= 1'b0;
      end else begin
        txDataQ[i] <= strobe.txFromRx ? rxDataIn[i] : txDataIn[i];
        rxDataQ[i] <= strobe.rxFromTx ? txDataIn[i] : rxDataIn[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txClkQ <= 1'b0;
      rxClkQ <= 1'b0;
    end else begin
      txClkQ <= strobe.txFromRx ? rxClkIn : txClkIn;
      rxClkQ <= strobe.rxFromTx ? txClkIn : rxClkIn;
    end
  end

  assign txDataOut = txDataQ;
  assign txClkOut  = txClkQ;
  assign rxDataOut = rxDataQ;
  assign rxClkOut  = rxClkQ;

endmodule

// File: rtl/line_loop_sel.sv
module line_loop_sel
  import llsPkg::*;
#(
  parameter int DATA_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hwSel,
  input  logic              swLocalEn,
  input  logic              swRemoteEn,
  input  logic [1:0]        strapCode,
  input  logic [DATA_W-1:0] rxDataIn,
  input  logic              rxClkIn,
  input  logic [DATA_W-1:0] txDataIn,
  input  logic              txClkIn,
  output logic [DATA_W-1:0] txDataOut,
  output logic              txClkOut,
  output logic [DATA_W-1:0] rxDataOut,
  output logic              rxClkOut,
  output logic [1:0]        modeStatus
);

  pathStrobeS strobe;
  loopModeE   effMode;

  lls_mode_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .hwSel     (hwSel),
    .swLocalEn (swLocalEn),
    .swRemoteEn(swRemoteEn),
    .strapCode (strapCode),
    .rxClkIn   (rxClkIn),
    .txClkIn   (txClkIn),
    .strobe    (strobe),
    .effMode   (effMode)
  );

  lls_datapath #(.DATA_W(DATA_W)) path_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rxDataIn (rxDataIn),
    .rxClkIn  (rxClkIn),
    .txDataIn (txDataIn),
    .txClkIn  (txClkIn),
    .txDataOut(txDataOut),
    .txClkOut (txClkOut),
    .rxDataOut(rxDataOut),
    .rxClkOut (rxClkOut)
  );

  assign modeStatus = effMode;

endmodule

// File: rtl/line_loop_sel_chk.sv
module line_loop_sel_chk #(
  parameter int DATA_W = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] rxDataIn,
  input logic              rxClkIn,
  input logic [DATA_W-1:0] txDataIn,
  input logic              txClkIn,
  input logic [DATA_W-1:0] txDataOut,
  input logic              txClkOut,
  input logic [DATA_W-1:0] rxDataOut,
  input logic              rxClkOut,
  input logic [1:0]        modeStatus
);

  // Set once a full cycle out of reset has passed, so $past is meaningful
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  assert_status_legal_R9: assert property (@(posedge clk) disable iff (!rstN)
    modeStatus != 2'b11);

  assert_normal_path_R4: assert property (@(posedge clk) disable iff (!rstN)
    (armed && modeStatus == 2'b00) |->
      (txDataOut == $past(txDataIn) && txClkOut == $past(txClkIn) &&
       rxDataOut == $past(rxDataIn) && rxClkOut == $past(rxClkIn)));

  assert_remote_path_R5: assert property (@(posedge clk) disable iff (!rstN)
    (armed && modeStatus == 2'b01) |->
      (txDataOut == $past(rxDataIn) && txClkOut == $past(rxClkIn) &&
       rxDataOut == $past(rxDataIn) && rxClkOut == $past(rxClkIn)));

  assert_local_path_R6: assert property (@(posedge clk) disable iff (!rstN)
    (armed && modeStatus == 2'b10) |->
      (rxDataOut == $past(txDataIn) && rxClkOut == $past(txClkIn) &&
       txDataOut == $past(txDataIn) && txClkOut == $past(txClkIn)));

  assert_enter_remote_edge_R7: assert property (@(posedge clk) disable iff (!rstN)
    (armed && modeStatus == 2'b01 && $past(modeStatus) != 2'b01) |-> txClkOut);

  assert_enter_local_edge_R7: assert property (@(posedge clk) disable iff (!rstN)
    (armed && modeStatus == 2'b10 && $past(modeStatus) != 2'b10) |-> rxClkOut);

  assert_leave_remote_edge_R7: assert property (@(posedge clk) disable iff (!rstN)
    (armed && modeStatus == 2'b00 && $past(modeStatus) == 2'b01) |-> txClkOut);

  assert_leave_local_edge_R7: assert property (@(posedge clk) disable iff (!rstN)
    (armed && modeStatus == 2'b00 && $past(modeStatus) == 2'b10) |-> rxClkOut);

endmodule

bind line_loop_sel line_loop_sel_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .rxDataIn  (rxDataIn),
  .rxClkIn   (rxClkIn),
  .txDataIn  (txDataIn),
  .txClkIn   (txClkIn),
  .txDataOut (txDataOut),
  .txClkOut  (txClkOut),
  .rxDataOut (rxDataOut),
  .rxClkOut  (rxClkOut),
  .modeStatus(modeStatus)
);

// File: tb/line_loop_sel_tb_top.sv
`timescale 1ns/1ps
module line_loop_sel_tb_top;
  localparam int W = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rstN, hwSel, swLocalEn, swRemoteEn, rxClkIn, txClkIn;
  logic [1:0]   strapCode, modeStatus;
  logic [W-1:0] rxDataIn, txDataIn, txDataOut, rxDataOut;
  logic         txClkOut, rxClkOut;

  line_loop_sel #(.DATA_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .hwSel(hwSel), .swLocalEn(swLocalEn),
    .swRemoteEn(swRemoteEn), .strapCode(strapCode), .rxDataIn(rxDataIn),
    .rxClkIn(rxClkIn), .txDataIn(txDataIn), .txClkIn(txClkIn),
    .txDataOut(txDataOut), .txClkOut(txClkOut), .rxDataOut(rxDataOut),
    .rxClkOut(rxClkOut), .modeStatus(modeStatus)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Reference model state
  logic [1:0]   mEff;
  logic         mPrx, mPtx;
  logic [W-1:0] eTxD, eRxD;
  logic         eTxC, eRxC;
  int           cyc = 0;
  bit           freezeClk = 1'b0;
  logic [7:0]   lfsr = 8'hA5;

  function automatic logic [1:0] reqOf(logic hw, logic l, logic r, logic [1:0] s);
    if (hw) return (s == 2'b01) ? 2'b01 : (s == 2'b10) ? 2'b10 : 2'b00;
    return l ? 2'b10 : (r ? 2'b01 : 2'b00);
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", tag, what, act, exp, cyc);
    end
  endtask

  task automatic step();
    logic [1:0] req, nxt;
    logic useRx, hit;
    string tagT, tagR;
    @(negedge clk);
    cyc++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rxDataIn = lfsr[1:0];
    txDataIn = lfsr[5:4];
    rxClkIn  = freezeClk ? 1'b0 : ((cyc % 6) >= 3);
    txClkIn  = freezeClk ? 1'b0 : ((cyc % 10) >= 5);
    req   = reqOf(hwSel, swLocalEn, swRemoteEn, strapCode);
    useRx = (req == 2'b01) ? 1'b1 : (req == 2'b10) ? 1'b0 : (mEff == 2'b10);
    hit   = useRx ? (rxClkIn & ~mPrx) : (txClkIn & ~mPtx);
    nxt   = (req != mEff && hit) ? req : mEff;
    eTxD  = (nxt == 2'b01) ? rxDataIn : txDataIn;
    eTxC  = (nxt == 2'b01) ? rxClkIn  : txClkIn;
    eRxD  = (nxt == 2'b10) ? txDataIn : rxDataIn;
    eRxC  = (nxt == 2'b10) ? txClkIn  : rxClkIn;
    tagT  = (nxt == 2'b01) ? "R5" : (nxt == 2'b10) ? "R6" : "R4";
    tagR  = tagT;
    mEff = nxt;
    mPrx = rxClkIn;
    mPtx = txClkIn;
    @(posedge clk);
    #1;
    check(tagT, int'(txDataOut), int'(eTxD), "txDataOut");
    check(tagT, int'(txClkOut),  int'(eTxC), "txClkOut");
    check(tagR, int'(rxDataOut), int'(eRxD), "rxDataOut");
    check(tagR, int'(rxClkOut),  int'(eRxC), "rxClkOut");
    check("R7", int'(modeStatus), int'(mEff), "modeStatus");
  endtask

  task automatic applyCfg(int c);
    hwSel      = c[4];
    swLocalEn  = c[3];
    swRemoteEn = c[2];
    strapCode  = c[1:0];
  endtask

  // Hold a config long enough for both bit clocks to rise, then check decode
  task automatic holdCfg(int c);
    logic [1:0] want;
    applyCfg(c);
    for (int k = 0; k < 12; k++) step();
    want = reqOf(c[4], c[3], c[2], c[1:0]);
    check(c[4] ? "R3" : "R2", int'(modeStatus), int'(want), "decoded status");
    check("R9", int'(modeStatus == 2'b11), 0, "illegal status");
  endtask

  initial begin
    rstN = 1'b0; hwSel = 1'b0; swLocalEn = 1'b0; swRemoteEn = 1'b0;
    strapCode = 2'b00; rxDataIn = '0; txDataIn = '0; rxClkIn = 1'b0; txClkIn = 1'b0;
    mEff = 2'b00; mPrx = 1'b0; mPtx = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", int'(txDataOut), 0, "txDataOut in reset");
    check("R1", int'(txClkOut), 0, "txClkOut in reset");
    check("R1", int'(rxDataOut), 0, "rxDataOut in reset");
    check("R1", int'(rxClkOut), 0, "rxClkOut in reset");
    check("R1", int'(modeStatus), 0, "modeStatus in reset");
    @(negedge clk);
    rstN = 1'b1;

    // Every ordered pair of configurations (R2..R7, R9)
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        holdCfg(a);
        holdCfg(b);
      end
    end

    // R8: request withdrawn while both bit clocks are frozen
    applyCfg(0);
    for (int k = 0; k < 12; k++) step();
    freezeClk = 1'b1;
    for (int k = 0; k < 4; k++) step();
    applyCfg(5'b00100);               // software remote request
    for (int k = 0; k < 3; k++) step();
    check("R8", int'(modeStatus), 0, "status while request pending");
    applyCfg(5'b10010);               // strap high: local request
    for (int k = 0; k < 3; k++) step();
    check("R8", int'(modeStatus), 0, "status while strap request pending");
    applyCfg(0);
    freezeClk = 1'b0;
    for (int k = 0; k < 12; k++) step();
    check("R8", int'(modeStatus), 0, "status after withdrawn requests");

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule